// File: doc/BRIEF.md
# Six-State Cyclic Pattern Sequencer

This block is a clocked Moore machine that holds a four-bit code and walks it around a fixed loop of six codes: 1001, 0011, 0111, 1111, 1110, 1100, and then back to 1001. The four code bits are the outputs, with no decode between the register and the pins. The top bit also drives a dedicated serial line. Read from the starting code, that line repeats the pattern 1,0,0,1,1,1.

There is no data input. The loop advances on every rising edge while the advance enable is high. A synchronous restart puts the machine back at 1001 at any time. An asynchronous active-low reset does the same, and its release is synchronised to the clock. Ten of the sixteen four-bit codes are not in the loop. If an upset leaves the register holding one of them, the next advancing edge returns it to 1001.

Top module: `seq6_sequencer`

## Requirements
- R1: While `rst_n` is low, `state_q` is 1001 and `ser_o` is 1, including immediately after an asynchronous assertion. After `rst_n` rises between edges, the code holds 1001 for SYNC_STAGES rising edges (default 2) and advances at the following edge.
- R2: On each rising edge with `adv_en` high and `restart` low, the code moves one step along 1001 → 0011 → 0111 → 1111 → 1110 → 1100 → 1001.
- R3: A rising edge with `restart` high loads 1001, whatever the value of `adv_en`. `restart` has priority over `adv_en`.
- R4: A rising edge with `adv_en` low and `restart` low leaves `state_q` unchanged.
- R5: `ser_o` always equals bit 3 of `state_q`. Starting from 1001, it produces 1,0,0,1,1,1 and then repeats.
- R6: The next-state function maps each of the six loop codes to its successor and each of the ten unused codes to 1001. Every code is therefore back in the loop within one advancing edge.
- R7: The outputs change only at rising clock edges while `rst_n` is high. Toggling `restart` or `adv_en` between edges leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| restart | input | 1 | Synchronous active-high return to 1001 |
| adv_en | input | 1 | Clock enable for stepping the loop |
| state_q | output | 4 | Current code, bit 3 down to bit 0 |
| ser_o | output | 1 | Serial output, equal to bit 3 of the code |

## Verification
The bench checks the reset-release latency edge by edge. A synchroniser of the wrong depth, or a missing one, shows up as an early or late first step. Two full loops are compared against an independently held code table and the serial pattern. The wrong successor, or the pattern shifted by one, fails there. Restart is exercised with the enable both high and low, so an inverted priority leaves the code on the successor of the current code instead of 1001. The next-state logic is swept over all sixteen codes, so an unused code that stalls, lands on another unused code, or lands on the wrong loop code is caught. Inputs are toggled between edges, which exposes any path from an input straight to an output.

// File: rtl/seq6_pkg.sv
package seq6_pkg;

  localparam int unsigned CODE_W  = 4;
  localparam int unsigned LOOP_LEN = 6;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t SEED_CODE = 4'b1001;

  // Loop order, entry 0 in the low nibble; the order is the behaviour.
  localparam logic [LOOP_LEN*CODE_W-1:0] LOOP_FLAT =
    {4'b1100, 4'b1110, 4'b1111, 4'b0111, 4'b0011, 4'b1001};

  function automatic code_t loop_code(input int unsigned idx);
    return LOOP_FLAT[idx*CODE_W +: CODE_W];
  endfunction

  function automatic logic on_loop(input code_t c);
    logic hit;
    hit = 1'b0;
    for (int unsigned k = 0; k < LOOP_LEN; k++) begin
      if (c == loop_code(k)) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/seq6_rst_sync.sv
module seq6_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[LAST];

endmodule

// File: rtl/seq6_next.sv
module seq6_next
  import seq6_pkg::*;
(
  input  code_t cur_i,
  output code_t nxt_o,
  output logic  on_loop_o
);

  logic [LOOP_LEN-1:0] match;

  // One comparator per loop position.
  for (genvar g = 0; g < LOOP_LEN; g++) begin : g_match
    assign match[g] = (cur_i == loop_code(g));
  end

  always_comb begin
    nxt_o = SEED_CODE;   // every off-loop code returns to the seed
    for (int unsigned i = 0; i < LOOP_LEN; i++) begin
      if (match[i]) nxt_o = loop_code((i + 1) % LOOP_LEN);
    end
    on_loop_o = |match;
  end

  always_comb begin
    if (!$isunknown(cur_i)) begin
      AST_SINGLE_MATCH: assert ($onehot0(match)); // R6
      AST_NEXT_ON_LOOP: assert (on_loop(nxt_o)); // R6
    end
  end

endmodule

// File: rtl/seq6_state_reg.sv
module seq6_state_reg
  import seq6_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart_i,
  input  logic  adv_i,
  input  code_t nxt_i,
  output code_t state_o
);

  code_t state_q;
  code_t state_d;
  logic  load_en;

  assign load_en = restart_i | adv_i;

  always_comb begin
    state_d = state_q;
    if (restart_i) begin
      state_d = SEED_CODE;
    end else if (adv_i) begin
      state_d = nxt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED_CODE;
    end else if (load_en) begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !adv_i) |=> $stable(state_o)); // R4
  AST_RESTART_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (state_o == SEED_CODE)); // R3
  AST_SEED_SUCC: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == SEED_CODE && adv_i && !restart_i) |=> (state_o == 4'b0011)); // R2
  AST_WRAP_SUCC: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'b1100 && adv_i && !restart_i) |=> (state_o == SEED_CODE)); // R2
  AST_STAY_ON_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    on_loop(state_o)); // R2

endmodule

// File: rtl/seq6_sequencer.sv
module seq6_sequencer
  import seq6_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              adv_en,
  output logic [CODE_W-1:0] state_q,
  output logic              ser_o
);

  logic  rst_sync_n;
  code_t cur_code;
  code_t nxt_code;
  logic  cur_on_loop;

  seq6_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seq6_next u_next (
    .cur_i     (cur_code),
    .nxt_o     (nxt_code),
    .on_loop_o (cur_on_loop)
  );

  seq6_state_reg u_state (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .restart_i (restart),
    .adv_i     (adv_en),
    .nxt_i     (nxt_code),
    .state_o   (cur_code)
  );

  assign state_q = cur_code;
  assign ser_o   = cur_code[CODE_W-1];

  AST_SER_IS_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ser_o == state_q[3]); // R5
  AST_ON_LOOP_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cur_on_loop); // R6

endmodule

// File: tb/test_seq6_sequencer.sv
`timescale 1ns/100ps
module test_seq6_sequencer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       restart;
  logic       adv_en;
  logic [3:0] state_q;
  logic       ser_o;

  logic [3:0] sw_cur;
  logic [3:0] sw_nxt;
  logic       sw_on;

  int n_chk  = 0;
  int n_fail = 0;

  logic [3:0] ring [6] = '{4'b1001, 4'b0011, 4'b0111, 4'b1111, 4'b1110, 4'b1100};
  bit         pat  [6] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

  always #2 clk = ~clk;

  seq6_sequencer i_seq6_sequencer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .adv_en  (adv_en),
    .state_q (state_q),
    .ser_o   (ser_o)
  );

  seq6_next i_next_sweep (
    .cur_i     (sw_cur),
    .nxt_o     (sw_nxt),
    .on_loop_o (sw_on)
  );

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int ring_idx(input logic [3:0] c);
    for (int k = 0; k < 6; k++) if (ring[k] == c) return k;
    return -1;
  endfunction

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int idx;
    rst_n = 1'b0; restart = 1'b0; adv_en = 1'b1; sw_cur = 4'd0;
    repeat (3) @(negedge clk);
    check("R1 reset code", state_q, 4'b1001);
    check("R1 reset ser", {3'b0, ser_o}, 4'd1);

    // release between edges; SYNC_STAGES=2 edges hold the seed
    rst_n = 1'b1;
    for (int e = 0; e < 2; e++) begin
      @(negedge clk);
      check("R1 release hold", state_q, 4'b1001);
    end

    // two full loops from the seed
    idx = 0;
    for (int s = 0; s < 12; s++) begin
      @(negedge clk);
      idx = (idx + 1) % 6;
      check("R2 step", state_q, ring[idx]);
      check("R5 ser", {3'b0, ser_o}, {3'b0, pat[idx]});
    end

    // hold with enable low (R4)
    adv_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    idx = (idx + 1) % 6;  // one edge taken before enable drop seen? no: dropped before edge
    idx = (idx + 5) % 6;
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      check("R4 hold", state_q, ring[idx]);
    end

    // advance two, then restart with enable high (R3)
    adv_en = 1'b1;
    @(negedge clk); idx = (idx + 1) % 6;
    @(negedge clk); idx = (idx + 1) % 6;
    check("R2 resume", state_q, ring[idx]);
    restart = 1'b1;
    @(negedge clk);
    check("R3 restart enabled", state_q, 4'b1001);
    @(negedge clk);
    check("R3 restart held", state_q, 4'b1001);
    restart = 1'b0;
    @(negedge clk);
    check("R3 after restart", state_q, 4'b0011);
    @(negedge clk);
    check("R2 after restart", state_q, 4'b0111);

    // restart with enable low
    adv_en = 1'b0; restart = 1'b1;
    @(negedge clk);
    check("R3 restart idle", state_q, 4'b1001);
    restart = 1'b0; adv_en = 1'b1;
    @(negedge clk);
    check("R2 step from seed", state_q, 4'b0011);

    // Moore: toggle inputs between edges (R7)
    for (int m = 0; m < 4; m++) begin
      logic [3:0] snap;
      @(negedge clk);
      snap = state_q;
      #0.4 restart = 1'b1; adv_en = 1'b0;
      #0.4 check("R7 no comb path", state_q, snap);
      restart = 1'b0; adv_en = 1'b1;
      #0.4 check("R7 no comb path", state_q, snap);
    end

    // asynchronous assertion mid-loop (R1)
    @(negedge clk);
    if (state_q == 4'b1001) @(negedge clk);
    rst_n = 1'b0;
    #0.5 check("R1 async assert", state_q, 4'b1001);
    @(negedge clk);
    check("R1 held in reset", state_q, 4'b1001);
    rst_n = 1'b1;
    @(negedge clk); check("R1 latency", state_q, 4'b1001);
    @(negedge clk); check("R1 latency", state_q, 4'b1001);
    @(negedge clk); check("R1 first step", state_q, 4'b0011);

    // exhaustive next-state sweep (R6)
    for (int c = 0; c < 16; c++) begin
      int ri;
      logic [3:0] exp;
      sw_cur = c[3:0];
      #0.1;
      ri = ring_idx(c[3:0]);
      exp = (ri < 0) ? 4'b1001 : ring[(ri + 1) % 6];
      check("R6 next-state", sw_nxt, exp);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule